// File: doc/BRIEF.md
# Sector Write-Buffer Program Sequencer

This block models the write side of a byte-wide nonvolatile memory. The memory sits behind a strobe-style interface: an active-low chip select, an active-low output enable, an active-low write strobe, an 18-bit address and an 8-bit data bus. A fast system clock samples every pin. A write does not store one byte. Each qualified strobe pulse drops one byte into a one-sector staging buffer. The address is taken when the joint write condition begins, and the data is taken from the last sample before the condition ends.

Once the first byte is staged, the block starts a gap timer. If no new joint write condition begins within that gap, the load window closes and a timed internal cycle runs. The cycle first erases the whole target sector and then writes the staged bytes into a behavioural array. The external buses are free for reads during that cycle. The status logic uses two outputs: a busy flag and the address of the most recent accepted byte. A sticky error flag records strobes that were refused.

The address splits into a 10-bit sector field (bits 17..8) and an 8-bit byte offset (bits 7..0). The behavioural array holds `MODEL_SECTORS` sectors, and the low bits of the sector field select among them. Every time value is a parameter in clock cycles.

Top module: `sector_prog_seq`

## Requirements
- R1: While reset is held and just after it is released, `busy`, `proto_err` and `dout_en` are 0 and `last_addr` is 0. Every array byte reads 8'hFF.
- R2: A byte load needs `cs_n`=0, `wr_n`=0 and `oe_n`=1 at the same time. It completes when `cs_n` or `wr_n` rises while `oe_n` is still 1. If `oe_n` is 0, no load happens and `last_addr` does not change.
- R3: A joint write condition that lasts fewer than `GLITCH_CYC` clock samples is discarded. One that lasts exactly `GLITCH_CYC` samples is accepted.
- R4: The stored address is the one present on the first sample of the joint write condition, which is the later of the two falling strobes. The stored data is the value on the last sample before the first strobe rises.
- R5: Bytes may be loaded at any offsets and in any order. After the cycle, each one reads back at its address. `last_addr` shows the address of the most recent accepted load on the sample after that load ends.
- R6: `busy` rises exactly `LOAD_GAP_CYC` clock samples after the sample on which the last accepted load ended, provided no joint write condition starts in between. A load that starts earlier keeps the window open.
- R7: `busy` stays high for exactly `PROG_CYC` samples. For the first `PROG_CYC/2` samples the sector keeps its old contents. For the rest of the cycle the sector reads 8'hFF, and then the staged bytes appear.
- R8: A qualified load that ends while `busy` is high is ignored. It does not change the array or `last_addr`, and it starts no new window. It sets `proto_err`, which stays set until reset.
- R9: During an open window, a load whose sector field differs from that of the window's first byte is ignored and sets `proto_err`.
- R10: Driving `cs_n`=0, `oe_n`=0 and `wr_n`=1 on a sample puts the array byte at `addr` on `dout` with `dout_en`=1 after that clock edge. On any other sample `dout_en` goes to 0.
- R11: Offsets in the sector that were not loaded during the window read 8'hFF after the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 18 | Sector field [17:8], byte offset [7:0] |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| dout_en | output | 1 | High when `dout` holds a read result |
| busy | output | 1 | Erase/program cycle in progress |
| last_addr | output | 18 | Address of the most recent accepted load |
| proto_err | output | 1 | Sticky flag for refused loads |

## Verification
Some properties are checked on every clock cycle:
- a short joint write pulse never moves `last_addr`;
- a low output enable never lets a load through;
- `last_addr` holds still during the busy cycle;
- the busy period lasts exactly `PROG_CYC` cycles;
- `busy` never rises in the middle of a write pulse;
- `dout_en` follows a read request;
- the error flag never clears.

Other behaviour only shows up in the bench's scenarios:
- which address and which data a pulse captures;
- the exact cycle on which the window closes;
- the old-then-erased-then-new sequence inside the cycle;
- readback of out-of-order loads;
- the refusal of foreign-sector and mid-cycle loads.

// File: rtl/secprog_pkg.sv
package secprog_pkg;

    localparam int ADDR_W     = 18;
    localparam int OFS_W      = 8;
    localparam int DATA_W     = 8;
    localparam int SEC_W      = ADDR_W - OFS_W;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam logic [DATA_W-1:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOAD,
        PH_ERASE,
        PH_WRITE
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } load_evt_t;

    function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFS_W];
    endfunction

    function automatic logic [OFS_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
        return a[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/secprog_strobe.sv
module secprog_strobe
    import secprog_pkg::*;
#(
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              in_pulse,
    output logic              ld_done,
    output load_evt_t         ld_evt
);

    localparam int CNT_W = $clog2(GLITCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(GLITCH_CYC);

    logic             joint_low;
    logic             joint_q;
    logic [CNT_W-1:0] width_q;
    load_evt_t        cap_q;

    // Write condition: both strobes low, output enable high.
    assign joint_low = !cs_n && !wr_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            joint_q <= 1'b0;
            width_q <= '0;
            cap_q   <= '0;
        end else begin
            joint_q <= joint_low;
            if (joint_low && !joint_q) begin
                // Later falling strobe: address taken here.
                cap_q.addr <= addr;
                cap_q.data <= din;
                width_q    <= CNT_W'(1);
            end else if (joint_low) begin
                // Data follows the bus until the first rising strobe.
                cap_q.data <= din;
                if (width_q != CNT_SAT) begin
                    width_q <= width_q + 1'b1;
                end
            end
        end
    end

    // A pulse counts only if a strobe rose with OE still high and it was wide enough.
    assign ld_done  = joint_q && !joint_low && oe_n && (width_q >= CNT_SAT);
    assign in_pulse = joint_low;
    assign ld_evt   = cap_q;

endmodule

// File: rtl/secprog_ctrl.sv
module secprog_ctrl
    import secprog_pkg::*;
#(
    parameter int LOAD_GAP_CYC = 15000,
    parameter int PROG_CYC     = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_done,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              in_pulse,
    output logic              accept,
    output logic              busy,
    output logic              erase_go,
    output logic              commit_go,
    output logic [SEC_W-1:0]  win_sec,
    output logic [ADDR_W-1:0] last_addr,
    output logic              proto_err
);

    localparam int ERASE_CYC = PROG_CYC / 2;
    localparam int WRITE_CYC = PROG_CYC - ERASE_CYC;
    localparam int GAP_W     = $clog2(LOAD_GAP_CYC + 1);
    localparam int TMR_W     = $clog2(PROG_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(LOAD_GAP_CYC - 1);
    localparam logic [TMR_W-1:0] ERASE_LAST = TMR_W'(ERASE_CYC - 1);
    localparam logic [TMR_W-1:0] WRITE_LAST = TMR_W'(WRITE_CYC - 1);

    phase_e           phase_q;
    logic [GAP_W-1:0] gap_q;
    logic [TMR_W-1:0] tmr_q;

    always_comb begin
        busy      = (phase_q == PH_ERASE) || (phase_q == PH_WRITE);
        accept    = ld_done && !busy &&
                    ((phase_q == PH_IDLE) || (sector_of(ld_addr) == win_sec));
        erase_go  = (phase_q == PH_ERASE) && (tmr_q == ERASE_LAST);
        commit_go = (phase_q == PH_WRITE) && (tmr_q == WRITE_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            gap_q     <= '0;
            tmr_q     <= '0;
            win_sec   <= '0;
            last_addr <= '0;
            proto_err <= 1'b0;
        end else begin
            if (ld_done && !accept) begin
                proto_err <= 1'b1;
            end
            if (accept) begin
                last_addr <= ld_addr;
            end
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_LOAD;
                        win_sec <= sector_of(ld_addr);
                        gap_q   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (accept) begin
                        gap_q <= '0;
                    end else if (!in_pulse) begin
                        if (gap_q == GAP_LAST) begin
                            phase_q <= PH_ERASE;
                            tmr_q   <= '0;
                        end else begin
                            gap_q <= gap_q + 1'b1;
                        end
                    end
                end
                PH_ERASE: begin
                    if (tmr_q == ERASE_LAST) begin
                        phase_q <= PH_WRITE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_WRITE: begin
                    if (tmr_q == WRITE_LAST) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/secprog_pagebuf.sv
module secprog_pagebuf
    import secprog_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr,
    input  logic [OFS_W-1:0]                     wr_ofs,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 clear,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    page_data,
    output logic [PAGE_BYTES-1:0]                page_vld
);

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic              vld_q;
        logic [DATA_W-1:0] dat_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else if (wr && (wr_ofs == OFS_W'(g))) begin
                vld_q <= 1'b1;
                dat_q <= wr_data;
            end
        end

        assign page_vld[g]  = vld_q;
        assign page_data[g] = dat_q;
    end

endmodule

// File: rtl/secprog_array.sv
module secprog_array
    import secprog_pkg::*;
#(
    parameter int MODEL_SECTORS = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              erase_go,
    input  logic                              commit_go,
    input  logic [$clog2(MODEL_SECTORS)-1:0]  win_idx,
    input  logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data,
    input  logic [PAGE_BYTES-1:0]             page_vld,
    input  logic                              rd_en,
    input  logic [$clog2(MODEL_SECTORS)+OFS_W-1:0] rd_idx,
    output logic [DATA_W-1:0]                 dout,
    output logic                              dout_en
);

    localparam int IDX_W     = $clog2(MODEL_SECTORS);
    localparam int MEM_AW    = IDX_W + OFS_W;
    localparam int MEM_BYTES = MODEL_SECTORS * PAGE_BYTES;

    logic [DATA_W-1:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < MEM_BYTES; j++) begin
                mem_q[MEM_AW'(j)] <= ERASED_BYTE;
            end
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (erase_go) begin
                    mem_q[{win_idx, OFS_W'(i)}] <= ERASED_BYTE;
                end else if (commit_go && page_vld[i]) begin
                    mem_q[{win_idx, OFS_W'(i)}] <= page_data[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_en;
            if (rd_en) begin
                dout <= mem_q[rd_idx];
            end
        end
    end

endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
    import secprog_pkg::*;
#(
    parameter int GLITCH_CYC    = 2,
    parameter int LOAD_GAP_CYC  = 15000,
    parameter int PROG_CYC      = 1000000,
    parameter int MODEL_SECTORS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [17:0]       addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy,
    output logic [17:0]       last_addr,
    output logic              proto_err
);

    localparam int IDX_W = $clog2(MODEL_SECTORS);

    logic                              in_pulse;
    logic                              ld_done;
    load_evt_t                         ld_evt;
    logic                              accept;
    logic                              erase_go;
    logic                              commit_go;
    logic [SEC_W-1:0]                  win_sec;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data;
    logic [PAGE_BYTES-1:0]             page_vld;
    logic                              rd_en;

    assign rd_en = !cs_n && !oe_n && wr_n;

    secprog_strobe #(
        .GLITCH_CYC(GLITCH_CYC)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .din      (din),
        .in_pulse (in_pulse),
        .ld_done  (ld_done),
        .ld_evt   (ld_evt)
    );

    secprog_ctrl #(
        .LOAD_GAP_CYC(LOAD_GAP_CYC),
        .PROG_CYC    (PROG_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ld_done   (ld_done),
        .ld_addr   (ld_evt.addr),
        .in_pulse  (in_pulse),
        .accept    (accept),
        .busy      (busy),
        .erase_go  (erase_go),
        .commit_go (commit_go),
        .win_sec   (win_sec),
        .last_addr (last_addr),
        .proto_err (proto_err)
    );

    secprog_pagebuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr        (accept),
        .wr_ofs    (offset_of(ld_evt.addr)),
        .wr_data   (ld_evt.data),
        .clear     (commit_go),
        .page_data (page_data),
        .page_vld  (page_vld)
    );

    secprog_array #(
        .MODEL_SECTORS(MODEL_SECTORS)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .erase_go  (erase_go),
        .commit_go (commit_go),
        .win_idx   (win_sec[IDX_W-1:0]),
        .page_data (page_data),
        .page_vld  (page_vld),
        .rd_en     (rd_en),
        .rd_idx    (addr[OFS_W+IDX_W-1:0]),
        .dout      (dout),
        .dout_en   (dout_en)
    );

endmodule

// File: rtl/secprog_chk.sv
module secprog_chk #(
    parameter int GLITCH_CYC = 2,
    parameter int PROG_CYC   = 1000000
) (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        oe_n,
    input logic        wr_n,
    input logic        dout_en,
    input logic        busy,
    input logic [17:0] last_addr,
    input logic        proto_err
);

    localparam int JW = $clog2(GLITCH_CYC + 1);
    localparam int BW = $clog2(PROG_CYC + 2);

    logic          jl;
    logic          jl_q;
    logic [JW-1:0] jl_cnt;
    logic [BW-1:0] busy_run;

    assign jl = !cs_n && !wr_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            jl_q     <= 1'b0;
            jl_cnt   <= '0;
            busy_run <= '0;
        end else begin
            jl_q <= jl;
            if (jl && !jl_q) begin
                jl_cnt <= JW'(1);
            end else if (jl && (jl_cnt != JW'(GLITCH_CYC))) begin
                jl_cnt <= jl_cnt + 1'b1;
            end
            if (!busy) begin
                busy_run <= '0;
            end else if (busy_run != BW'(PROG_CYC + 1)) begin
                busy_run <= busy_run + 1'b1;
            end
        end
    end

    AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (jl_q && !jl && (jl_cnt < JW'(GLITCH_CYC))) |=> $stable(last_addr)); // R3

    AST_OE_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        !oe_n |=> $stable(last_addr)); // R2

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(last_addr)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R8

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < BW'(PROG_CYC))); // R7

    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == BW'(PROG_CYC))); // R7

    AST_NO_RISE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(jl)); // R6

    AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!cs_n && !oe_n && wr_n)); // R10

endmodule

bind sector_prog_seq secprog_chk #(
    .GLITCH_CYC(GLITCH_CYC),
    .PROG_CYC  (PROG_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .wr_n      (wr_n),
    .dout_en   (dout_en),
    .busy      (busy),
    .last_addr (last_addr),
    .proto_err (proto_err)
);

// File: tb/sector_prog_seq_test.sv
module sector_prog_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int GL   = 3;
    localparam int GAP  = 20;
    localparam int PROG = 40;
    localparam int ERC  = PROG / 2;
    localparam int WD   = 20000;

    // {offset, data}, deliberately out of order
    localparam logic [15:0] TBL [8] = '{
        16'h07A5, 16'hF012, 16'h0033, 16'h80C4,
        16'h1F5E, 16'hFF99, 16'h4001, 16'h2B7E
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1;
    logic [17:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, busy, proto_err;
    logic [17:0] last_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sector_prog_seq #(
        .GLITCH_CYC(GL), .LOAD_GAP_CYC(GAP), .PROG_CYC(PROG), .MODEL_SECTORS(4)
    ) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .busy(busy), .last_addr(last_addr), .proto_err(proto_err)
    );

    function automatic logic [17:0] mk(input int sec, input int ofs);
        return {10'(sec), 8'(ofs)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(input logic [17:0] a, input logic [7:0] d, input int w);
        addr = a; din = d; oe_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        repeat (w) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd(input logic [17:0] a, output logic [7:0] d, output logic e);
        addr = a; cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1;
        @(negedge clk);
        d = dout; e = dout_en;
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic settle();
        repeat (GAP + PROG + 4) @(negedge clk);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic        e;
        logic [17:0] keep;

        do_reset();
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "proto_err", proto_err, 0);
        chk("R1", "dout_en", dout_en, 0);
        chk("R1", "last_addr", last_addr, 0);
        rd(mk(2, 8'h33), d, e);
        chk("R1", "erased array", d, 8'hFF);

        // R5/R2 table walk: out-of-order loads into sector 1
        for (int i = 0; i < 8; i++) begin
            load(mk(1, TBL[i][15:8]), TBL[i][7:0], GL + 1);
            @(negedge clk);
        end
        chk("R5", "last_addr after walk", last_addr, mk(1, TBL[7][15:8]));
        settle();
        for (int i = 0; i < 8; i++) begin
            rd(mk(1, TBL[i][15:8]), d, e);
            chk("R5", "readback", d, TBL[i][7:0]);
            chk("R10", "dout_en on read", e, 1);
        end
        @(negedge clk);
        chk("R10", "dout_en idle", dout_en, 0);
        rd(mk(1, 8'h55), d, e);
        chk("R11", "unloaded byte", d, 8'hFF);
        rd(mk(0, TBL[0][15:8]), d, e);
        chk("R10", "other sector untouched", d, 8'hFF);

        // R6/R7 window close timing and erase-then-program sequence
        load(mk(1, TBL[0][15:8]), 8'h6C, GL);
        repeat (GAP) @(negedge clk);
        chk("R6", "busy before gap expiry", busy, 0);
        @(negedge clk);
        chk("R6", "busy at gap expiry", busy, 1);
        rd(mk(1, TBL[1][15:8]), d, e);
        chk("R7", "old data during erase phase", d, TBL[1][7:0]);
        repeat (ERC) @(negedge clk);
        rd(mk(1, TBL[1][15:8]), d, e);
        chk("R7", "erased during program phase", d, 8'hFF);
        repeat (PROG - 3 - ERC) @(negedge clk);
        chk("R7", "busy on last cycle", busy, 1);
        @(negedge clk);
        chk("R7", "busy after PROG cycles", busy, 0);
        rd(mk(1, TBL[0][15:8]), d, e);
        chk("R7", "new data committed", d, 8'h6C);
        rd(mk(1, TBL[1][15:8]), d, e);
        chk("R11", "byte not reloaded", d, 8'hFF);

        // R3 glitch rejection and exact-width acceptance
        keep = last_addr;
        load(mk(3, 8'h44), 8'h11, GL - 1);
        repeat (GAP + 3) @(negedge clk);
        chk("R3", "short pulse no window", busy, 0);
        chk("R3", "short pulse last_addr", last_addr, keep);
        load(mk(3, 8'h44), 8'h22, GL);
        @(negedge clk);
        chk("R3", "exact width accepted", last_addr, mk(3, 8'h44));
        settle();
        rd(mk(3, 8'h44), d, e);
        chk("R3", "exact width data", d, 8'h22);

        // R2 output enable low inhibits
        keep = last_addr;
        addr = mk(2, 8'h01); din = 8'h77; oe_n = 1'b0; cs_n = 1'b0; wr_n = 1'b0;
        repeat (10) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
        repeat (GAP + 3) @(negedge clk);
        chk("R2", "OE low no window", busy, 0);
        chk("R2", "OE low last_addr", last_addr, keep);

        // R4 address at later fall, data at first rise (chip-select controlled)
        addr = mk(0, 8'h0F); din = 8'h01; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = mk(0, 8'hA0); din = 8'h5B; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        din = 8'hC3;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; din = 8'hEE; addr = mk(0, 8'h0E);
        @(negedge clk);
        wr_n = 1'b1;
        chk("R4", "address at later falling strobe", last_addr, mk(0, 8'hA0));
        settle();
        rd(mk(0, 8'hA0), d, e);
        chk("R4", "data at first rising strobe", d, 8'hC3);

        // R8 loads during busy are refused
        do_reset();
        load(mk(2, 8'h05), 8'h5A, GL);
        repeat (GAP + 1) @(negedge clk);
        chk("R8", "busy entered", busy, 1);
        load(mk(2, 8'h06), 8'h66, GL + 1);
        @(negedge clk);
        chk("R8", "proto_err set", proto_err, 1);
        chk("R8", "last_addr frozen", last_addr, mk(2, 8'h05));
        settle();
        chk("R8", "no new window", busy, 0);
        chk("R8", "proto_err sticky", proto_err, 1);
        rd(mk(2, 8'h06), d, e);
        chk("R8", "refused byte absent", d, 8'hFF);
        rd(mk(2, 8'h05), d, e);
        chk("R8", "earlier byte kept", d, 8'h5A);

        // R9 foreign sector within a window
        do_reset();
        load(mk(3, 8'h01), 8'h31, GL);
        @(negedge clk);
        load(mk(1, 8'h02), 8'h12, GL);
        @(negedge clk);
        chk("R9", "proto_err on foreign sector", proto_err, 1);
        chk("R9", "last_addr unchanged", last_addr, mk(3, 8'h01));
        settle();
        rd(mk(3, 8'h01), d, e);
        chk("R9", "window byte committed", d, 8'h31);
        rd(mk(1, 8'h02), d, e);
        chk("R9", "foreign byte dropped", d, 8'hFF);

        // R6 window extension by a late but timely load
        load(mk(0, 8'h80), 8'hA1, GL);
        repeat (GAP - 1) @(negedge clk);
        chk("R6", "still loading", busy, 0);
        load(mk(0, 8'h81), 8'hA2, GL);
        repeat (GAP) @(negedge clk);
        chk("R6", "extended window open", busy, 0);
        settle();
        rd(mk(0, 8'h80), d, e);
        chk("R6", "first byte", d, 8'hA1);
        rd(mk(0, 8'h81), d, e);
        chk("R6", "second byte", d, 8'hA2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule